// File: doc/BRIEF.md
# Embedded Operation Status Responder

This block chooses the word returned on every read of a flash-style memory. A separate sequencer decodes commands and times the internal program or erase. While that operation runs, or waits to run, this block returns a status word instead of array contents. A host can poll the status word to learn whether the operation is still going, whether it has run out of time, and whether an erase can still accept more sectors.

The sequencer signals three things on this block's inputs. It pulses a start input, together with the operation type, on the final write of a command sequence. It pulses a done input when the operation completes. It pulses a timeout input if the operation runs over its time limit. A level input reports whether the sector-erase acceptance window is still open.

The status word carries five kinds of information:
- a polarity bit on bit 7 that flips when the operation completes,
- a toggle bit on bit 6 that advances once per completed read,
- a sticky over-time flag on bit 5,
- an erase-window flag on bit 3,
- zeros everywhere else.

When the done pulse arrives, the output returns to array data in that same cycle.

Top module: `opstat_responder`

## Requirements
- R1: After reset, `status_sel` is 0 and `rd_data` equals `array_data`. A start pulse with `op_kind` 2'b01 (program) or 2'b10 (erase) switches the output to the status word from the next cycle. A start pulse with `op_kind` 2'b00 is ignored.
- R2: During a program, status bit 7 is the inverse of `prog_data[7]`.
- R3: During an erase, status bit 7 is 0. This holds both while the acceptance window is open and after the erase has begun.
- R4: Status bit 6 inverts once for each falling edge of `rd_strobe` while status is shown. The new value is visible from the cycle after the falling edge. A read held high for many cycles does not change it. Every new operation starts with bit 6 at 0.
- R5: Status bit 5 becomes 1 the cycle after a `time_limit` pulse during an operation. It stays 1 until `reset_cmd`. While bit 5 is 1, `op_done` is ignored and status remains shown.
- R6: During an erase, status bit 3 is 0 while `window_open` is 1 and 1 while `window_open` is 0. During a program, status bit 3 is 0.
- R7: In the cycle where `op_done` is 1 and no timeout is pending, `rd_data` equals `array_data` and `status_sel` is 0. The output stays on array data afterwards.
- R8: While status is shown, bits 4, 2, 1 and 0 of `rd_data` are 0, and so is every bit above bit 7.
- R9: A `reset_cmd` pulse ends status output from the next cycle and clears bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse on the final write of a command sequence |
| op_kind | input | 2 | Operation type: 01 program, 10 erase, 00 none |
| prog_data | input | 8 | Data byte being programmed |
| op_done | input | 1 | Completion pulse from the sequencer |
| time_limit | input | 1 | Pulse when the operation runs over its time limit |
| window_open | input | 1 | High while the erase acceptance window is open |
| reset_cmd | input | 1 | Pulse when a reset command is decoded |
| rd_strobe | input | 1 | High during a host read |
| array_data | input | DATA_W | Word read from the array |
| rd_data | output | DATA_W | Word returned to the host |
| status_sel | output | 1 | High while the status word is selected |

## Verification
The bench builds the block with DATA_W set to 16 rather than the default of 8. The wider word puts the bits above the status byte within reach, so the check that they read zero (R8) means something, and array passthrough is tested on a full word. Flag behaviour uses the default bit layout. The bench drives reads held for several cycles so that falling-edge toggling can be told apart from level-driven toggling.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic [1:0] {
    OPK_NONE  = 2'b00,
    OPK_PROG  = 2'b01,
    OPK_ERASE = 2'b10
  } opk_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_OVER = 5;
  localparam int BIT_WIN  = 3;

  // Build the status byte from its flag inputs.
  function automatic logic [7:0] status_byte(input opk_e kind, input logic pbit,
                                             input logic tog, input logic over,
                                             input logic win_open);
    logic [7:0] s;
    s = 8'h00;
    s[BIT_POLL] = (kind == OPK_PROG) ? ~pbit : 1'b0;
    s[BIT_TOG]  = tog;
    s[BIT_OVER] = over;
    s[BIT_WIN]  = (kind == OPK_ERASE) ? ~win_open : 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/opstat_flags.sv
module opstat_flags
  import opstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  input  logic       op_done,
  input  logic       time_limit,
  input  logic       reset_cmd,
  output logic       busy,
  output opk_e       kind,
  output logic       over,
  output logic       start_ok
);
  logic done_ok;

  assign start_ok = op_start && (op_kind == OPK_PROG || op_kind == OPK_ERASE);
  assign done_ok  = op_done && !over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      kind <= OPK_NONE;
      over <= 1'b0;
    end else if (reset_cmd) begin
      busy <= 1'b0;
      over <= 1'b0;
    end else if (start_ok) begin
      busy <= 1'b1;
      kind <= opk_e'(op_kind);
      over <= 1'b0;
    end else begin
      if (busy && time_limit) over <= 1'b1;
      if (done_ok) busy <= 1'b0;
    end
  end

  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !reset_cmd && !start_ok) |=> over) else $error("over flag dropped"); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (!busy && !over)) else $error("reset_cmd did not clear"); // R9
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic rd_strobe,
  output logic tog
);
  logic rd_q;
  logic rd_fall;

  assign rd_fall = rd_q && !rd_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_strobe;
      if (clear)                 tog <= 1'b0;
      else if (enable && rd_fall) tog <= ~tog;
    end
  end

  AST_TOG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rd_fall && !clear) |=> (tog != $past(tog))) else $error("no toggle"); // R4

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fall && !clear) |=> $stable(tog)) else $error("spurious toggle"); // R4
endmodule

// File: rtl/opstat_encode.sv
module opstat_encode
  import opstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              show,
  input  opk_e              kind,
  input  logic [7:0]        prog_data,
  input  logic              tog,
  input  logic              over,
  input  logic              window_open,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = DATA_W - 8;
  logic [7:0] sbyte;
  logic [DATA_W-1:0] sword;

  assign sbyte = status_byte(kind, prog_data[BIT_POLL], tog, over, window_open);

  generate
    if (HI_W > 0) begin : g_wide
      assign sword = {{HI_W{1'b0}}, sbyte};
    end else begin : g_byte
      assign sword = sbyte;
    end
  endgenerate

  assign rd_data = show ? sword : array_data;
endmodule

// File: rtl/opstat_responder.sv
module opstat_responder
  import opstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [7:0]        prog_data,
  input  logic              op_done,
  input  logic              time_limit,
  input  logic              window_open,
  input  logic              reset_cmd,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              status_sel
);
  logic busy;
  opk_e kind;
  logic over;
  logic start_ok;
  logic tog;
  logic release_now;

  opstat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_done(op_done), .time_limit(time_limit), .reset_cmd(reset_cmd),
    .busy(busy), .kind(kind), .over(over), .start_ok(start_ok)
  );

  assign release_now = op_done && !over;
  assign status_sel  = busy && !release_now;

  opstat_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .enable(status_sel),
    .rd_strobe(rd_strobe), .tog(tog)
  );

  opstat_encode #(.DATA_W(DATA_W)) u_enc (
    .show(status_sel), .kind(kind), .prog_data(prog_data), .tog(tog),
    .over(over), .window_open(window_open), .array_data(array_data),
    .rd_data(rd_data)
  );

  AST_PROG_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel && kind == OPK_PROG) |-> (rd_data[7] == ~prog_data[7])) else $error("poll bit"); // R2

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel && kind == OPK_ERASE) |-> !rd_data[7]) else $error("erase poll"); // R3

  AST_WINDOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel && kind == OPK_ERASE) |-> (rd_data[3] == !window_open)) else $error("window"); // R6

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000)) else $error("spare bits"); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done && !over) |-> (rd_data == array_data)) else $error("release"); // R7

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == array_data && !status_sel)) else $error("idle pass"); // R1
endmodule

// File: tb/opstat_responder_tb.sv
module opstat_responder_tb;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_done = 0, time_limit = 0, window_open = 0, reset_cmd = 0, rd_strobe = 0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] prog_data = 8'h00;
  logic [DW-1:0] array_data = 16'h1234;
  logic [DW-1:0] rd_data;
  logic status_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  opstat_responder #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_data(prog_data), .op_done(op_done), .time_limit(time_limit),
    .window_open(window_open), .reset_cmd(reset_cmd), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data), .status_sel(status_sel)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic start(input logic [1:0] k, input logic [7:0] pd);
    @(negedge clk); op_kind = k; prog_data = pd; op_start = 1;
    @(negedge clk); op_start = 0; #1;
  endtask

  task automatic one_read();
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset data", rd_data, 16'h1234);
    chk("R1 reset sel", {15'd0, status_sel}, 16'd0);
    start(2'b00, 8'h00);
    chk("R1 kind none ignored", rd_data, 16'h1234);
  endtask

  task automatic t_program();
    array_data = 16'h1234;
    start(2'b01, 8'h5A);
    chk("R1 status sel", {15'd0, status_sel}, 16'd1);
    chk("R2 R8 program status", rd_data, 16'h0080);
    @(negedge clk); rd_strobe = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 long read holds", rd_data, 16'h0080);
    end
    @(negedge clk); rd_strobe = 0;
    step();
    chk("R4 toggle after fall", rd_data, 16'h00C0);
    one_read();
    chk("R4 toggle back", rd_data, 16'h0080);
    one_read();
    chk("R4 toggle again", rd_data, 16'h00C0);
    @(negedge clk); op_done = 1; #1;
    chk("R7 same cycle release", rd_data, 16'h1234);
    @(negedge clk); op_done = 0; #1;
    chk("R7 stays array", rd_data, 16'h1234);
    one_read();
    chk("R4 no toggle when idle", rd_data, 16'h1234);
    start(2'b01, 8'hA5);
    chk("R2 R4 program bit7 0 toggle restart", rd_data, 16'h0000);
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0; #1;
  endtask

  task automatic t_erase();
    array_data = 16'hFFFF;
    window_open = 1;
    start(2'b10, 8'h00);
    chk("R3 R6 erase window open", rd_data, 16'h0000);
    @(negedge clk); window_open = 0; #1;
    chk("R3 R6 erase begun", rd_data, 16'h0008);
    one_read();
    chk("R4 erase toggle", rd_data, 16'h0048);
    @(negedge clk); op_done = 1; #1;
    chk("R7 erase release", rd_data, 16'hFFFF);
    @(negedge clk); op_done = 0; #1;
  endtask

  task automatic t_timeout();
    array_data = 16'h00FF;
    start(2'b01, 8'h80);
    chk("R2 program bit7 clear", rd_data, 16'h0000);
    @(negedge clk); time_limit = 1;
    @(negedge clk); time_limit = 0; #1;
    chk("R5 over flag", rd_data, 16'h0020);
    @(negedge clk); op_done = 1; #1;
    chk("R5 done ignored", {15'd0, status_sel}, 16'd1);
    @(negedge clk); op_done = 0; #1;
    chk("R5 still over", rd_data, 16'h0020);
    repeat (3) step();
    chk("R5 sticky", rd_data, 16'h0020);
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0; #1;
    chk("R9 reset to array", rd_data, 16'h00FF);
    start(2'b10, 8'h00);
    chk("R9 R5 flag cleared", rd_data, 16'h0008);
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0; #1;
    chk("R9 erase reset", rd_data, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_program();
    t_erase();
    t_timeout();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule